// File: doc/BRIEF.md
# Asynchronous Memory Half-Word Packing Adapter

This block joins a single-outstanding internal request port, 32 bits wide, to an external asynchronous memory bus. That bus has four chip-select banks. The two most significant request address bits select the bank. A small control register sets three things: which banks answer, whether each bank is wired to a full 32-bit device or to a 16-bit device, and whether an external clock-enable strobe runs during accesses.

When a bank is marked as 16-bit, a 32-bit request is split into two back-to-back external strobes, and the read halves are joined into one response. Byte and half-word requests still take one strobe. In that mode only the low sixteen data lines are used. The lane-3 byte-enable pin carries the half-word address bit, and the lane-2 byte-enable pin stays high. A request to a bank that is switched off gets an error response and drives no strobe at all. Request write data and response read data are right-justified, and the adapter moves them onto the proper byte lanes.

Top module: `amem_pack_adapter`

## Requirements
- R1: The control register resets to 0x00F2. Bit 0 is the clock enable, bits 2:1 are the bank-enable field, and bits 7:4 are the 16-bit mode flags for banks 0 to 3. Every other bit reads zero, so writing 0xFFFF reads back 0x00F7.
- R2: The bank is req_addr[ADDR_W-1:ADDR_W-2]. Bank-enable value 0 enables no bank, 1 enables bank 0, 2 enables banks 0 and 1, and 3 enables all four. An enabled bank responds with rsp_err low, and at most one mem_cs_n bit is ever low.
- R3: A request to a disabled bank drives no chip select or strobe. Its response comes one cycle after acceptance, with rsp_err high and rsp_rdata zero.
- R4: req_ready is high only when no request is in progress. rsp_valid is a one-cycle pulse, and req_ready stays low from acceptance until the cycle after that pulse.
- R5: A request to a bank in 32-bit mode takes exactly one strobe cycle, for any size. req_size 0 is a byte, 1 is a half-word, and 2 or 3 is a word. mem_be_n is active low with bit i for data lane i (bits 8i+7:8i). The response follows the strobe by one cycle.
- R6: A word request to a bank in 16-bit mode takes two consecutive strobe cycles. In the first, mem_be_n[3] is 0 and it carries the low half-word. In the second, mem_be_n[3] is 1 and it carries the high half-word. The response comes the cycle after the second strobe, with both halves assembled.
- R7: A byte or half-word request to a bank in 16-bit mode takes one strobe, with mem_be_n[3] equal to req_addr[1]. For a half-word, mem_be_n[1:0] is 00. For a byte, mem_be_n[1:0] is 10 when req_addr[0] is 0 and 01 when it is 1.
- R8: In 16-bit mode, mem_be_n[2] stays high during strobes, write data goes only on mem_wdata[15:0] with mem_wdata[31:16] zero, and mem_rdata[31:16] is ignored.
- R9: mem_clk_en is high exactly in strobe cycles when register bit 0 is set. It is low at all other times.
- R10: Write data is taken from the low bits of req_wdata and read data returns right-justified in rsp_rdata. Address bits below the access size are ignored: bit 0 for half-words, and bits 1:0 for words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write value |
| cfg_rdata | output | CFG_W | Control register contents |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_addr | input | ADDR_W | Byte address, top two bits select the bank |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request hit a disabled bank |
| rsp_rdata | output | 32 | Right-justified read data |
| mem_cs_n | output | 4 | Active-low bank selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_addr | output | ADDR_W-2 | External word address |
| mem_be_n | output | 4 | Active-low byte enables, bit 3 is the half-word address in 16-bit mode |
| mem_wdata | output | 32 | External write data |
| mem_rdata | input | 32 | External read data, sampled at the end of each strobe cycle |
| mem_clk_en | output | 1 | External clock enable during accesses |

## Verification
The packing assertions read the 16-bit mode flags from the live register contents. They therefore assume the control register is not rewritten while a request is in flight. The bench writes the register only between requests, after each response has arrived. The external memory model answers within the strobe cycle, because there are no wait states. The bench keeps req_valid high for exactly the accepting cycle and never issues a second request before the response.

// File: rtl/amem_pkg.sv
package amem_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int BANKS  = 4;
    localparam int BANK_W = $clog2(BANKS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC1 = 2'd1,
        ST_ACC2 = 2'd2,
        ST_RESP = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic              clk_en;
        logic [1:0]        bank_en;
        logic [BANKS-1:0]  pack_en;
    } cfg_t;
endpackage

// File: rtl/amem_cfg_reg.sv
module amem_cfg_reg
    import amem_pkg::*;
#(
    parameter int              CFG_W     = 16,
    parameter logic [CFG_W-1:0] RESET_VAL = CFG_W'(16'h00F2),
    parameter logic [CFG_W-1:0] WR_MASK   = CFG_W'(16'h00F7)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output cfg_t             cfg
);
    logic [CFG_W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (we) begin
            reg_d = wdata & WR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= RESET_VAL;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rdata       = reg_q;
    assign cfg.clk_en  = reg_q[0];
    assign cfg.bank_en = reg_q[2:1];
    assign cfg.pack_en = reg_q[4 +: BANKS];
endmodule

// File: rtl/amem_bank_gate.sv
module amem_bank_gate
    import amem_pkg::*;
(
    input  logic [1:0]        bank_en,
    input  logic [BANKS-1:0]  pack_en,
    input  logic [BANK_W-1:0] bank,
    output logic              bank_ok,
    output logic              bank_pk
);
    logic [BANKS-1:0] en_mask;

    for (genvar i = 0; i < BANKS; i++) begin : g_mask
        if (i == 0) begin : g_b0
            assign en_mask[i] = (bank_en != 2'b00);
        end else if (i == 1) begin : g_b1
            assign en_mask[i] = bank_en[1];
        end else begin : g_hi
            assign en_mask[i] = (bank_en == 2'b11);
        end
    end

    assign bank_ok = en_mask[bank];
    assign bank_pk = pack_en[bank];
endmodule

// File: rtl/amem_lane_map.sv
module amem_lane_map
    import amem_pkg::*;
(
    input  logic              pk,
    input  logic [1:0]        size,
    input  logic [1:0]        lo_addr,
    input  logic              half_sel,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [3:0]        be_n,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_just
);
    always_comb begin
        be_n       = 4'hF;
        wdata_out  = '0;
        rdata_just = '0;
        if (pk) begin
            be_n[2] = 1'b1;
            be_n[3] = lo_addr[1];
            if (size[1]) begin
                be_n[3]               = half_sel;
                be_n[1:0]             = 2'b00;
                wdata_out[HALF_W-1:0] = half_sel ? wdata_in[DATA_W-1:HALF_W]
                                                 : wdata_in[HALF_W-1:0];
                rdata_just            = {{HALF_W{1'b0}}, rdata_in[HALF_W-1:0]};
            end else if (size[0]) begin
                be_n[1:0]             = 2'b00;
                wdata_out[HALF_W-1:0] = wdata_in[HALF_W-1:0];
                rdata_just            = {{HALF_W{1'b0}}, rdata_in[HALF_W-1:0]};
            end else begin
                be_n[1:0]             = lo_addr[0] ? 2'b01 : 2'b10;
                wdata_out[HALF_W-1:0] = lo_addr[0] ? {wdata_in[7:0], 8'h00}
                                                   : {8'h00, wdata_in[7:0]};
                rdata_just            = {24'h0, lo_addr[0] ? rdata_in[15:8]
                                                           : rdata_in[7:0]};
            end
        end else begin
            if (size[1]) begin
                be_n       = 4'b0000;
                wdata_out  = wdata_in;
                rdata_just = rdata_in;
            end else if (size[0]) begin
                be_n       = lo_addr[1] ? 4'b0011 : 4'b1100;
                wdata_out  = lo_addr[1] ? {wdata_in[HALF_W-1:0], {HALF_W{1'b0}}}
                                        : {{HALF_W{1'b0}}, wdata_in[HALF_W-1:0]};
                rdata_just = {{HALF_W{1'b0}}, lo_addr[1] ? rdata_in[DATA_W-1:HALF_W]
                                                         : rdata_in[HALF_W-1:0]};
            end else begin
                be_n       = ~(4'b0001 << lo_addr);
                wdata_out  = {24'h0, wdata_in[7:0]} << {lo_addr, 3'b000};
                rdata_just = {24'h0, 8'(rdata_in >> {lo_addr, 3'b000})};
            end
        end
    end
endmodule

// File: rtl/amem_seq.sv
module amem_seq
    import amem_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bank_ok,
    input  logic              bank_pk,
    input  logic [DATA_W-1:0] lane_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              acc_active,
    output logic              acc_write,
    output logic [1:0]        acc_size,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_pk,
    output logic              acc_half,
    output logic [DATA_W-1:0] acc_wdata
);
    typedef struct packed {
        seq_st_e           st;
        logic              write;
        logic [1:0]        size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              pk;
        logic              err;
        logic              half;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.write = req_write;
                    s_d.size  = req_size;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.pk    = bank_pk;
                    s_d.err   = !bank_ok;
                    s_d.half  = 1'b0;
                    s_d.rdata = '0;
                    s_d.st    = bank_ok ? ST_ACC1 : ST_RESP;
                end
            end
            ST_ACC1: begin
                if (s_q.pk && s_q.size[1]) begin
                    if (!s_q.write) begin
                        s_d.rdata[HALF_W-1:0] = lane_rdata[HALF_W-1:0];
                    end
                    s_d.half = 1'b1;
                    s_d.st   = ST_ACC2;
                end else begin
                    if (!s_q.write) begin
                        s_d.rdata = lane_rdata;
                    end
                    s_d.st = ST_RESP;
                end
            end
            ST_ACC2: begin
                if (!s_q.write) begin
                    s_d.rdata[DATA_W-1:HALF_W] = lane_rdata[HALF_W-1:0];
                end
                s_d.st = ST_RESP;
            end
            ST_RESP: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, size: 2'b00, addr: '0, wdata: '0,
                     rdata: '0, default: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.st == ST_IDLE);
    assign rsp_valid  = (s_q.st == ST_RESP);
    assign rsp_err    = rsp_valid && s_q.err;
    assign rsp_rdata  = rsp_valid ? s_q.rdata : '0;
    assign acc_active = (s_q.st == ST_ACC1) || (s_q.st == ST_ACC2);
    assign acc_write  = s_q.write;
    assign acc_size   = s_q.size;
    assign acc_addr   = s_q.addr;
    assign acc_pk     = s_q.pk;
    assign acc_half   = s_q.half;
    assign acc_wdata  = s_q.wdata;
endmodule

// File: rtl/amem_pack_adapter.sv
module amem_pack_adapter
    import amem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic [3:0]        mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [3:0]        mem_be_n,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              mem_clk_en
);
    cfg_t              cfg;
    logic              bank_ok, bank_pk;
    logic              acc_active, acc_write, acc_pk, acc_half;
    logic [1:0]        acc_size;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic [3:0]        lane_be_n;
    logic [DATA_W-1:0] lane_wdata, lane_rdata;
    logic [BANK_W-1:0] acc_bank;

    amem_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    amem_bank_gate u_gate (
        .bank_en (cfg.bank_en),
        .pack_en (cfg.pack_en),
        .bank    (req_addr[ADDR_W-1 -: BANK_W]),
        .bank_ok (bank_ok),
        .bank_pk (bank_pk)
    );

    amem_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .bank_ok    (bank_ok),
        .bank_pk    (bank_pk),
        .lane_rdata (lane_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .acc_active (acc_active),
        .acc_write  (acc_write),
        .acc_size   (acc_size),
        .acc_addr   (acc_addr),
        .acc_pk     (acc_pk),
        .acc_half   (acc_half),
        .acc_wdata  (acc_wdata)
    );

    amem_lane_map u_lanes (
        .pk         (acc_pk),
        .size       (acc_size),
        .lo_addr    (acc_addr[1:0]),
        .half_sel   (acc_half),
        .wdata_in   (acc_wdata),
        .rdata_in   (mem_rdata),
        .be_n       (lane_be_n),
        .wdata_out  (lane_wdata),
        .rdata_just (lane_rdata)
    );

    assign acc_bank = acc_addr[ADDR_W-1 -: BANK_W];

    for (genvar i = 0; i < BANKS; i++) begin : g_cs
        assign mem_cs_n[i] = !(acc_active && (acc_bank == BANK_W'(i)));
    end

    assign mem_rd_n   = !(acc_active && !acc_write);
    assign mem_wr_n   = !(acc_active && acc_write);
    assign mem_addr   = acc_active ? acc_addr[ADDR_W-1:2] : '0;
    assign mem_be_n   = acc_active ? lane_be_n : 4'hF;
    assign mem_wdata  = (acc_active && acc_write) ? lane_wdata : '0;
    assign mem_clk_en = acc_active && cfg.clk_en;
endmodule

// File: rtl/amem_pack_adapter_chk.sv
module amem_pack_adapter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [3:0]  mem_cs_n,
    input logic        mem_rd_n,
    input logic        mem_wr_n,
    input logic [3:0]  mem_be_n,
    input logic [15:0] wdata_hi,
    input logic        mem_clk_en,
    input logic [3:0]  pack_en
);
    logic strobe_any, packed_strobe;
    assign strobe_any    = (mem_cs_n != 4'hF);
    assign packed_strobe = |(~mem_cs_n & pack_en);

    assert_one_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ($past(mem_cs_n) == 4'hF));

    assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_ready_not_during_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_any |-> !req_ready);

    assert_strobe_has_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> (strobe_any && (mem_rd_n != mem_wr_n)));

    assert_pack_lane2_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        packed_strobe |-> mem_be_n[2]);

    assert_pack_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (packed_strobe && !mem_wr_n) |-> (wdata_hi == 16'h0));

    assert_clk_en_only_in_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clk_en |-> strobe_any);
endmodule

bind amem_pack_adapter amem_pack_adapter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .mem_cs_n   (mem_cs_n),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .mem_be_n   (mem_be_n),
    .wdata_hi   (mem_wdata[31:16]),
    .mem_clk_en (mem_clk_en),
    .pack_en    (cfg_rdata[7:4])
);

// File: tb/amem_pack_adapter_tb.sv
module amem_pack_adapter_tb;
    localparam int ADDR_W = 12;
    localparam int CFG_W  = 16;
    localparam int NBYTE  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [CFG_W-1:0]  cfg_rdata;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic [3:0]        mem_cs_n;
    logic              mem_rd_n, mem_wr_n;
    logic [ADDR_W-3:0] mem_addr;
    logic [3:0]        mem_be_n;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = 32'hDEADBEEF;
    logic              mem_clk_en;

    always #5 clk = ~clk;

    amem_pack_adapter #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_dut (.*);

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [7:0] model [0:NBYTE-1];
    logic [7:0] refm  [0:NBYTE-1];
    logic [3:0] pack_cfg = 4'hF;
    logic       clk_cfg  = 1'b0;
    int         mon_n    = 0;
    int         mon_bad  = 0;
    logic [3:0] mon_be [0:3];

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // external memory model: 16-bit banks take the half-word address from be_n[3]
    always @(negedge clk) begin
        if (mem_cs_n != 4'hF) begin
            int bk;
            bk = 0;
            for (int i = 0; i < 4; i++) if (!mem_cs_n[i]) bk = i;
            if (mon_n < 4) mon_be[mon_n] = mem_be_n;
            mon_n++;
            if (mem_clk_en !== clk_cfg) mon_bad++;
            if (pack_cfg[bk]) begin
                if (!mem_be_n[2]) mon_bad++;
                if (!mem_wr_n) begin
                    if (mem_wdata[31:16] != 16'h0) mon_bad++;
                    for (int i = 0; i < 2; i++)
                        if (!mem_be_n[i]) model[{mem_addr, mem_be_n[3], i[0]}] = mem_wdata[8*i +: 8];
                end else begin
                    mem_rdata = {16'hA5C3, model[{mem_addr, mem_be_n[3], 1'b1}],
                                 model[{mem_addr, mem_be_n[3], 1'b0}]};
                end
            end else begin
                if (!mem_wr_n) begin
                    for (int i = 0; i < 4; i++)
                        if (!mem_be_n[i]) model[{mem_addr, i[1:0]}] = mem_wdata[8*i +: 8];
                end else begin
                    for (int i = 0; i < 4; i++) mem_rdata[8*i +: 8] = model[{mem_addr, i[1:0]}];
                end
            end
        end else begin
            if (mem_clk_en) mon_bad++;
            mem_rdata = 32'hDEADBEEF;
        end
    end

    task automatic wr_cfg(input logic [CFG_W-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        pack_cfg = v[7:4];
        clk_cfg  = v[0];
    endtask

    task automatic do_req(input logic w, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output logic err,
                          output int nstb, output int cyc);
        @(negedge clk);
        check(req_ready === 1'b1, "R4 ready when idle", {31'b0, req_ready}, 32'h1);
        mon_n = 0; mon_bad = 0;
        req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 20) begin
            if (req_ready) mon_bad++;
            @(negedge clk);
            cyc++;
        end
        rd = rsp_rdata; err = rsp_err; nstb = mon_n;
        if (req_ready) mon_bad++;
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] h, wa;
        h  = {a[ADDR_W-1:1], 1'b0};
        wa = {a[ADDR_W-1:2], 2'b00};
        if (sz[1])      return {refm[wa+3], refm[wa+2], refm[wa+1], refm[wa]};
        else if (sz[0]) return {16'h0, refm[h+1], refm[h]};
        else            return {24'h0, refm[a]};
    endfunction

    task automatic ref_wr(input logic [1:0] sz, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [ADDR_W-1:0] h, wa;
        h  = {a[ADDR_W-1:1], 1'b0};
        wa = {a[ADDR_W-1:2], 2'b00};
        if (sz[1]) for (int i = 0; i < 4; i++) refm[wa + i] = d[8*i +: 8];
        else if (sz[0]) begin refm[h] = d[7:0]; refm[h+1] = d[15:8]; end
        else refm[a] = d[7:0];
    endtask

    function automatic logic [3:0] exp_be(input logic pk, input logic [1:0] sz,
                                          input logic [1:0] lo, input int idx);
        if (pk) begin
            if (sz[1])      return {idx[0], 3'b100};
            else if (sz[0]) return {lo[1], 3'b100};
            else            return {lo[1], 1'b1, lo[0] ? 2'b01 : 2'b10};
        end
        if (sz[1])      return 4'b0000;
        else if (sz[0]) return lo[1] ? 4'b0011 : 4'b1100;
        else            return ~(4'b0001 << lo);
    endfunction

    task automatic run_txn(input logic w, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                           input logic [31:0] wd);
        logic [31:0] rd, exp;
        logic        err, pk;
        int          nstb, cyc, en;
        pk  = pack_cfg[a[ADDR_W-1 -: 2]];
        en  = (pk && sz[1]) ? 2 : 1;
        exp = exp_rd(sz, a);
        do_req(w, sz, a, wd, rd, err, nstb, cyc);
        check(err == 1'b0, "R2 enabled bank no error", {31'b0, err}, 32'h0);
        check(nstb == en, pk ? (sz[1] ? "R6 two strobes" : "R7 one strobe") : "R5 one strobe",
              nstb, en);
        check(cyc == en + 1, "R4 R5 R6 response latency", cyc, en + 1);
        for (int i = 0; i < en && i < nstb; i++)
            check(mon_be[i] == exp_be(pk, sz, a[1:0], i),
                  pk ? (sz[1] ? "R6 half order be_n" : "R7 packed be_n") : "R5 be_n lanes",
                  {28'h0, mon_be[i]}, {28'h0, exp_be(pk, sz, a[1:0], i)});
        check(mon_bad == 0, "R8 R9 R4 bus monitor", mon_bad, 0);
        if (w) begin
            logic [ADDR_W-1:0] wa;
            logic [31:0] mw, rw;
            ref_wr(sz, a, wd);
            wa = {a[ADDR_W-1:2], 2'b00};
            mw = {model[wa+3], model[wa+2], model[wa+1], model[wa]};
            rw = {refm[wa+3], refm[wa+2], refm[wa+1], refm[wa]};
            check(mw == rw, "R10 R8 write lanes in memory", mw, rw);
        end else begin
            check(rd == exp, pk ? "R6 R10 packed read data" : "R10 read data", rd, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < NBYTE; i++) begin
            model[i] = 8'(i * 7 + 3);
            refm[i]  = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_rdata == 16'h00F2, "R1 reset value", {16'h0, cfg_rdata}, 32'h00F2);
        check(rsp_valid == 1'b0 && mem_cs_n == 4'hF && mem_clk_en == 1'b0,
              "R1 R9 idle outputs after reset", {27'h0, rsp_valid, mem_cs_n}, 32'h0F);
        wr_cfg(16'hFFFF);
        check(cfg_rdata == 16'h00F7, "R1 unused bits read zero", {16'h0, cfg_rdata}, 32'h00F7);

        for (int cf = 0; cf < 2; cf++) begin
            logic [3:0] pk;
            pk = (cf == 0) ? 4'b0101 : 4'b1010;
            wr_cfg({8'h00, pk, 1'b0, 2'b11, (cf == 0)});
            for (int bk = 0; bk < 4; bk++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    for (int off = 0; off < 4; off++) begin
                        logic [ADDR_W-1:0] a;
                        logic [31:0] wd, rd;
                        logic err;
                        int nstb, cyc;
                        if (sz == 1 && off[0]) continue;
                        if (sz == 2 && off != 0) continue;
                        a  = {bk[1:0], 8'(sz * 8 + cf * 40 + 5), off[1:0]};
                        wd = 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101) ^ (32'(sz) << 28);
                        run_txn(1'b1, sz[1:0], a, wd);
                        run_txn(1'b0, sz[1:0], a, 32'h0);
                        run_txn(1'b0, 2'd2, {a[ADDR_W-1:2], 2'b00}, 32'h0);
                        // low address bits below the access size are ignored
                        if (sz == 1) run_txn(1'b0, 2'd1, a | 1, 32'h0);
                        if (sz == 2) run_txn(1'b0, 2'd3, a | 3, 32'h0);
                        if (bk == 0 && sz == 0 && off == 0) begin
                            do_req(1'b0, 2'd0, a, 32'h0, rd, err, nstb, cyc);
                        end
                    end
                end
            end
        end

        for (int be = 0; be < 4; be++) begin
            wr_cfg({8'h00, 4'b0000, 1'b0, be[1:0], 1'b1});
            for (int bk = 0; bk < 4; bk++) begin
                logic [ADDR_W-1:0] a;
                logic [31:0] rd;
                logic err;
                int nstb, cyc;
                bit en;
                en = (be == 3) || (be == 2 && bk < 2) || (be == 1 && bk == 0);
                a  = {bk[1:0], 8'h3C, 2'b00};
                do_req(1'b0, 2'd2, a, 32'h0, rd, err, nstb, cyc);
                check(err == !en, "R2 bank enable decode", {31'b0, err}, {31'b0, !en});
                if (!en) begin
                    check(nstb == 0 && cyc == 1, "R3 disabled bank quiet", nstb * 16 + cyc, 1);
                    check(rd == 32'h0, "R3 disabled bank data zero", rd, 32'h0);
                end else begin
                    check(nstb == 1, "R5 enabled one strobe", nstb, 1);
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule